// File: doc/BRIEF.md
# Pointer-Addressed Register Slave on a Two-Wire Serial Bus

This block is an I2C slave that gives a bus master access to a register file. The register file sits outside the block. Both bus lines are sampled in the system clock domain, and START and STOP conditions are recovered from those samples. A single open-drain enable drives the data line low whenever the slave acknowledges or sends a zero bit.

The device address has two parts. Six bits are fixed at `100101`, and the seventh comes from a strap input that is captured while reset is asserted. A write transfer works as follows:

- The first byte after the address loads an internal pointer.
- Each further byte is written to the register that the pointer selects.

A read transfer returns register contents starting at the pointer. Pointer bit 7 chooses the pointer behaviour: either it stays on one register, or it steps to the next register after every byte moved.

The register file is reached through a write strobe port and a read port. The read port returns data one clock after the read address is presented. The pointer survives STOP and repeated START, so the usual way to read is in two steps:

1. A short write that sets the pointer.
2. A repeated START into a read.

Top module: `i2c_regfile_slave`

## Requirements
- R1: While `rst` is high and on the clock after it, `sda_oe` is 0 and `reg_we` is 0.
- R2: Two conditions are decoded while SCL is high. SDA falling is a START and begins address reception. SDA rising is a STOP, which releases SDA and returns the slave to idle. Bus bits sent after a STOP with no new START are ignored (no acknowledge, no write). `sda_oe` changes only after an SCL falling edge, a START or a STOP.
- R3: The first byte after START is taken MSB first. Bits [7:1] must equal `100101` followed by the latched strap level. Bit 0 is R/W, where 1 means read. On a match the slave holds SDA low for the whole ninth clock.
- R4: A first byte that does not match is not acknowledged. All later bytes are then ignored, with SDA never driven and no writes, until the next START.
- R5: `strap_lsb` is captured on every clock while `rst` is high and held after that. Changing it outside reset does not change the address.
- R6: In a write, the byte after the address loads the pointer. Bit 7 is the increment enable and bits [AW-1:0] are the register index. The pointer byte is acknowledged.
- R7: Each further write byte is acknowledged and produces exactly one `reg_we` pulse, one clock wide, with `reg_waddr` equal to the pointer index and `reg_wdata` equal to the byte.
- R8: After each byte written or sent, the index advances by one modulo 2^AW when the increment enable is 1. When the enable is 0 the index stays the same.
- R9: In a read, the slave sends the register at the pointer, MSB first. It changes SDA only while SCL is low. `reg_raddr` always shows the pointer index, and `reg_rdata` must be valid one clock later.
- R10: When the master acknowledges in the ninth clock of a read byte, the slave sends the next byte. When the master does not acknowledge, the slave releases SDA and ignores the bus until the next START.
- R11: The pointer keeps its value across a STOP and across a repeated START. A repeated START restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_lsb | input | 1 | Address bit 0 strap, captured during reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_we | output | 1 | Register file write strobe |
| reg_waddr | output | AW | Register file write index |
| reg_wdata | output | 8 | Register file write data |
| reg_raddr | output | AW | Register file read index (the pointer) |
| reg_rdata | input | 8 | Register file read data, one clock after `reg_raddr` |

## Verification
The bench plays the bus master. It uses these patterns:

- **Incrementing bursts:** show that the pointer steps, including the wrap from the top index to zero.
- **Fixed-pointer bursts:** show that every byte lands on one register, which separates the two pointer behaviours.
- **Pointer write, repeated START, read:** tests pointer retention. A later read with no pointer byte, after a STOP, separates "kept across STOP" from "reset on STOP".

Mismatching addresses, stray bytes after a STOP, and a strap change outside reset followed by a new reset show that only the address captured in reset is recognised.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  localparam logic [5:0] DEV_ADDR_HI = 6'b100101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_TX,
    ST_MACK
  } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_d, sda_d;
  logic              scl_s, sda_s;

  // synchronizer chains, idle bus level after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff[0] <= 1'b1;
      sda_ff[0] <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else begin
        scl_ff[g] <= scl_ff[g-1];
        sda_ff[g] <= sda_ff[g-1];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_q     = sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_load,
  input  logic [7:0]    ptr_val,
  input  logic          ptr_step,
  output logic [AW-1:0] ptr_addr,
  output logic          ptr_incr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_addr <= '0;
      ptr_incr <= 1'b0;
    end else if (ptr_load) begin
      ptr_addr <= ptr_val[AW-1:0];
      ptr_incr <= ptr_val[7];
    end else if (ptr_step && ptr_incr) begin
      ptr_addr <= ptr_addr + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_rs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_q,
  input  logic          strap_q,
  input  logic [AW-1:0] ptr_addr,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          ptr_load,
  output logic [7:0]    ptr_val,
  output logic          ptr_step
);

  slv_state_t state;
  logic [7:0] shreg;
  logic [2:0] bit_cnt;
  logic       got_byte;
  logic       rw_q;
  logic       mack_q;
  logic       addr_hit;

  assign addr_hit = (shreg[7:1] == {DEV_ADDR_HI, strap_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bit_cnt  <= '0;
      got_byte <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      ptr_load <= 1'b0;
      ptr_val  <= '0;
      ptr_step <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      ptr_load <= 1'b0;
      ptr_step <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        got_byte <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        got_byte <= 1'b0;
        sda_oe   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (scl_rise && !got_byte) begin
              shreg   <= {shreg[6:0], sda_q};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == 3'd7) got_byte <= 1'b1;
            end else if (scl_fall && got_byte) begin
              got_byte <= 1'b0;
              bit_cnt  <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  rw_q   <= shreg[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                ptr_load <= 1'b1;
                ptr_val  <= shreg;
                sda_oe   <= 1'b1;
                state    <= ST_PTR_ACK;
              end else begin
                wr_en    <= 1'b1;
                wr_addr  <= ptr_addr;
                wr_data  <= shreg;
                ptr_step <= 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                shreg    <= rd_data;
                sda_oe   <= ~rd_data[7];
                bit_cnt  <= '0;
                ptr_step <= 1'b1;
                state    <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_oe  <= ~shreg[6];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_q;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg    <= rd_data;
                sda_oe   <= ~rd_data[7];
                bit_cnt  <= '0;
                ptr_step <= 1'b1;
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
            state <= ST_IDLE;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strap_lsb,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [7:0]    reg_wdata,
  output logic [AW-1:0] reg_raddr,
  input  logic [7:0]    reg_rdata
);

  localparam int DEPTH = 1 << AW;

  logic          strap_q;
  logic          sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic          ptr_load, ptr_step, ptr_incr;
  logic [7:0]    ptr_val;
  logic [AW-1:0] ptr_addr;

  // address strap is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_lsb;
  end

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ptr_unit #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .ptr_step (ptr_step),
    .ptr_addr (ptr_addr),
    .ptr_incr (ptr_incr)
  );

  i2c_slave_fsm #(.AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_q     (sda_q),
    .strap_q   (strap_q),
    .ptr_addr  (ptr_addr),
    .rd_data   (reg_rdata),
    .sda_oe    (sda_oe),
    .wr_en     (reg_we),
    .wr_addr   (reg_waddr),
    .wr_data   (reg_wdata),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_step  (ptr_step)
  );

  assign reg_raddr = ptr_addr;

  initial begin
    if (AW < 1 || AW > 7) $error("AW out of range, DEPTH=%0d", DEPTH);
  end

endmodule

// File: rtl/i2c_regfile_slave_chk.sv
module i2c_regfile_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic reg_we,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic strap_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sda_oe && !reg_we));

  // R2
  oe_timing_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R11
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R7
  we_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(scl_fall));

  // R5
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(strap_q));

endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .strap_q   (strap_q)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;

  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_lsb = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [AW-1:0] reg_waddr, reg_raddr;
  logic [7:0] reg_wdata, reg_rdata;
  logic bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int quiet_viol = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;

  logic [7:0]    exp_mem [NREG];
  logic [AW-1:0] m_ptr;
  bit            m_incr;
  logic [11:0]   wq[$];
  logic [7:0]    bmem [NREG];

  always #4 clk = ~clk;

  assign bus = sda_m & ~sda_oe;

  i2c_regfile_slave #(.AW(AW)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .strap_lsb (strap_lsb),
    .scl_i     (scl_m),
    .sda_i     (bus),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata)
  );

  function automatic logic [7:0] seed(int i);
    return 8'(8'h20 + 7 * i);
  endfunction

  // external register file stand-in: one-clock read latency
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bmem[i] <= seed(i);
    end else if (reg_we) begin
      bmem[reg_waddr] <= reg_wdata;
    end
    reg_rdata <= bmem[reg_raddr];
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the write port and of quiet windows
  always @(negedge clk) begin
    cyc++;
    if (!rst && reg_we) begin
      if (wq.size() == 0) begin
        check(1'b0, "R7", "unexpected write", {reg_waddr, reg_wdata}, 0);
      end else begin
        logic [11:0] e;
        e = wq.pop_front();
        check({reg_waddr, reg_wdata} == e, "R7", "write port", {reg_waddr, reg_wdata}, e);
      end
    end
    if (quiet && sda_oe) quiet_viol++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      summary();
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl_m = 1'b0; hw(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H / 2);
    ack = !bus; hw(H / 2);
    scl_m = 1'b0; hw(2);
  endtask

  task automatic recv_byte(input bit ackit, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H);
      scl_m = 1'b1; hw(H / 2);
      b[i] = bus; hw(H / 2);
      scl_m = 1'b0;
    end
    sda_m = !ackit; hw(H);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0; hw(1);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] waddr_byte();
    return {6'b100101, strap_lsb, 1'b0};
  endfunction

  task automatic model_ptr(input logic [7:0] p);
    m_ptr  = p[AW-1:0];
    m_incr = p[7];
  endtask

  task automatic model_step();
    if (m_incr) m_ptr = m_ptr + 1'b1;
  endtask

  task automatic do_reset(input bit strap);
    strap_lsb = strap;
    rst = 1'b1; hw(4);
    rst = 1'b0; hw(2);
    for (int i = 0; i < NREG; i++) exp_mem[i] = seed(i);
    m_ptr = '0; m_incr = 1'b0;
  endtask

  // write: pointer byte then n data bytes
  task automatic do_write(input logic [7:0] p, input int n, input logic [7:0] d0,
                          input logic [7:0] d1, input logic [7:0] d2, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte({6'b100101, strap_lsb, 1'b0}, ack);
    check(ack, "R3", "address ack", ack, 1);
    send_byte(p, ack);
    check(ack, "R6", "pointer ack", ack, 1);
    model_ptr(p);
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      wq.push_back({m_ptr, d});
      exp_mem[m_ptr] = d;
      model_step();
      send_byte(d, ack);
      check(ack, req, "data ack", ack, 1);
    end
    i2c_stop();
    hw(4);
    check(wq.size() == 0, req, "writes seen", wq.size(), 0);
  endtask

  // read n bytes from the current pointer, last one not acknowledged
  task automatic read_bytes(input int n, input string req);
    logic [7:0] b;
    logic [7:0] e;
    for (int k = 0; k < n; k++) begin
      e = exp_mem[m_ptr];
      model_step();
      recv_byte(k != n - 1, b);
      check(b == e, req, "read data", b, e);
    end
    hw(4);
    check(sda_oe == 1'b0, "R10", "released after nack", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) exp_mem[i] = seed(i);
    m_ptr = '0; m_incr = 1'b0;
    hw(6);
    // R1 reset state
    check(sda_oe == 1'b0, "R1", "sda_oe in reset", sda_oe, 0);
    check(reg_we == 1'b0, "R1", "reg_we in reset", reg_we, 0);
    do_reset(1'b1);
    check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

    // R8 incrementing burst
    do_write(8'h83, 3, 8'hA1, 8'hB2, 8'hC3, "R8");
    // R8 fixed-pointer burst, R7 strobes
    do_write(8'h07, 2, 8'h5A, 8'h6B, 8'h00, "R7");

    // R11 pointer write, repeated START, R9 read burst
    i2c_start();
    send_byte(waddr_byte(), ack);
    send_byte(8'h83, ack);
    model_ptr(8'h83);
    i2c_start();
    send_byte(waddr_byte() | 8'h01, ack);
    check(ack, "R11", "read address ack after repeated start", ack, 1);
    read_bytes(3, "R9");
    i2c_stop();

    // R11 pointer kept across STOP
    i2c_start();
    send_byte(waddr_byte() | 8'h01, ack);
    read_bytes(1, "R11");
    i2c_stop();

    // R8 read with fixed pointer, R10 master ack loads next
    i2c_start();
    send_byte(waddr_byte(), ack);
    send_byte(8'h07, ack);
    model_ptr(8'h07);
    i2c_start();
    send_byte(waddr_byte() | 8'h01, ack);
    read_bytes(2, "R10");
    i2c_stop();

    // R8 wrap from top index
    do_write(8'h8F, 2, 8'h11, 8'h22, 8'h00, "R8");

    // R4 mismatched strap bit and mismatched upper bits
    quiet = 1'b1; quiet_viol = 0;
    i2c_start();
    send_byte(8'h94, ack);
    check(!ack, "R4", "nack strap mismatch", ack, 0);
    send_byte(8'h82, ack);
    send_byte(8'hEE, ack);
    i2c_stop();
    i2c_start();
    send_byte(8'hB6, ack);
    check(!ack, "R4", "nack upper mismatch", ack, 0);
    send_byte(8'h44, ack);
    i2c_stop();
    hw(4);
    quiet = 1'b0;
    check(quiet_viol == 0, "R4", "SDA driven while ignored", quiet_viol, 0);

    // R2 stray bytes after STOP are ignored
    i2c_start();
    send_byte(waddr_byte(), ack);
    send_byte(8'h82, ack);
    model_ptr(8'h82);
    i2c_stop();
    quiet = 1'b1; quiet_viol = 0;
    scl_m = 1'b0; hw(H);
    send_byte(8'h99, ack);
    check(!ack, "R2", "no ack after stop", ack, 0);
    scl_m = 1'b1; hw(H);
    quiet = 1'b0;
    check(quiet_viol == 0, "R2", "SDA driven after stop", quiet_viol, 0);
    i2c_start();
    send_byte(waddr_byte() | 8'h01, ack);
    read_bytes(1, "R2");
    i2c_stop();

    // R5 strap change outside reset has no effect
    strap_lsb = 1'b0;
    i2c_start();
    send_byte(8'h96, ack);
    check(ack, "R5", "old address still acked", ack, 1);
    i2c_stop();
    quiet = 1'b1; quiet_viol = 0;
    i2c_start();
    send_byte(8'h94, ack);
    check(!ack, "R5", "new level not used", ack, 0);
    i2c_stop();
    quiet = 1'b0;

    // R5 strap captured on the next reset
    do_reset(1'b0);
    i2c_start();
    send_byte(8'h94, ack);
    check(ack, "R5", "address after new reset", ack, 1);
    i2c_stop();
    i2c_start();
    send_byte(8'h96, ack);
    check(!ack, "R5", "old address after new reset", ack, 0);
    i2c_stop();
    hw(8);

    check(wq.size() == 0, "R7", "pending writes", wq.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule